// File: doc/BRIEF.md
# Segmented Paged Address Translation Sequencer

This block turns a segment number and a word offset into a 24-bit absolute memory address. It works through a fixed set of named memory cycles. The first cycles read the segment descriptor, either straight from a flat descriptor table or through one page of a paged descriptor table. Next it reads the page-table entry of the target page and writes that entry back with its use and change flags updated. Last it makes the final operand or instruction access. If a segment-descriptor or page-entry hit is supplied by an external lookaside memory, the matching fetch cycles are skipped. A bounds violation or a page fault stops the sequence at the cycle where it happens.

Every cycle loads a 12-bit cycle status word. Bits 11 down to 3 name the cycle in progress, and bits 2 down to 0 hold the fault code of the most recent fault. An absolute-mode request skips translation and makes one access at the raw offset.

Segment descriptor layout (36 bits): base address in bits 35..12, bound in bits 11..1, paged flag in bit 0. The bound is counted in 128-word blocks, and an offset fails the check when offset[17:7] > bound. Page entry layout: frame number in bits 35..22, use flag U in bit 2, change flag M in bit 1, fault flag F in bit 0. Pages hold 1024 words.

Top module: `segx_top`

## Requirements
- R1: After reset, req_ready is 1, and mem_req, done, fault and cyc_status are all 0.
- R2: Flat descriptor table with an unpaged segment: the block reads the descriptor at dbase_addr+seg, then accesses sdw.base+offset. done pulses high for exactly one cycle, with rsp_addr set to the final address. mem_req is never high in two consecutive cycles.
- R3: Paged descriptor table: the block reads the entry at dbase_addr+seg[14:10]. The very next cycle writes that same entry back with U (bit 2) set. Then it reads the descriptor at {frame, seg[9:0]}.
- R4: Paged segment: the block reads the entry at sdw.base+offset[17:10], then writes it back with U set and with M set when the access is a store (req_kind=1). The final address is {frame, offset[9:0]}.
- R5: A descriptor hit skips every descriptor cycle. A page-entry hit also skips the entry read and the write-back, except that a store whose hit entry has M=0 still performs the write-back.
- R6: With req_prepage=1, the block reads the entry that follows the page's entry after the write-back and before the final access. Its frame is not used for the final address.
- R7: seg > dbase_bound in a descriptor-table cycle, or offset[17:7] > sdw.bound in a page-table or final cycle, raises fault with fault_code 1 before that cycle's memory access. No check is made during the paged descriptor read.
- R8: An entry read with F=1 (descriptor-table entry, page entry or prepage entry) raises fault with fault_code 2. No further memory access is issued.
- R9: cyc_status one-hot cycle bits: 10 descriptor-table entry read/write-back, 9 flat descriptor read, 8 paged descriptor read, 7 page entry read/write-back, 6 prepage read, 5 paged final, 4 flat final, 3 absolute final. Bit 11 is additionally set for instruction fetch (req_kind=2).
- R10: Loading a new cycle status changes only bits 11..3. Bits 2..0 keep the last fault code until the next fault.
- R11: With req_abs=1, the block makes one access at the zero-extended offset and sets cycle bit 3.
- R12: A store final cycle writes req_wdata at the final address. A read returns the memory word on rsp_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken when req_ready) |
| req_ready | output | 1 | Sequencer idle |
| req_seg | input | 15 | Segment number |
| req_off | input | 18 | Word offset |
| req_kind | input | 2 | 0 read, 1 store, 2 instruction fetch |
| req_prepage | input | 1 | Check the following page entry |
| req_abs | input | 1 | Absolute mode, no translation |
| req_wdata | input | 36 | Store data |
| dbase_addr | input | 24 | Descriptor table base |
| dbase_bound | input | 15 | Highest legal segment number |
| dbase_paged | input | 1 | Descriptor table is paged |
| desc_hit | input | 1 | Descriptor lookaside hit |
| desc_word | input | 36 | Descriptor from lookaside |
| pte_hit | input | 1 | Page entry lookaside hit |
| pte_word | input | 36 | Page entry from lookaside |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 36 | Memory write data |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | 36 | Memory read data, valid with mem_ack |
| done | output | 1 | Final access completed (one cycle) |
| rsp_addr | output | 24 | Final absolute address |
| rsp_rdata | output | 36 | Read data of the final access |
| fault | output | 1 | Sequence aborted (one cycle) |
| fault_code | output | 3 | 1 bounds, 2 page fault |
| cyc_status | output | 12 | Cycle status word |

## Verification
The bench runs the translation over the four combinations of flat or paged descriptor table and unpaged or paged segment. For each one it records the exact order of memory addresses and write flags, which shows whether every cycle was taken or skipped. Descriptor-only hits, both hits on a read and both hits on a store with a clean change flag separate the three skipping rules. Prepage requests with a clear and a set fault flag on the following entry show that the peek is a check only. Bound and fault-flag cases at each kind of cycle confirm that the sequence stops where the fault arises and that the fault code survives into later status words.

// File: rtl/segx_pkg.sv
package segx_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DSEG_RD,     // flat descriptor read
    S_DPAGE_RD,    // descriptor-table page entry read
    S_DPAGE_WB,    // descriptor-table page entry write-back
    S_DSEG_PG_RD,  // paged descriptor read
    S_PAGE_RD,     // page entry read
    S_PAGE_WB,     // page entry write-back
    S_PAGE_PEEK,   // prepage entry check
    S_FIN_PG,      // paged final access
    S_FIN_FLAT,    // unpaged final access
    S_FIN_ABS      // absolute final access
  } st_e;

  localparam logic [1:0] K_READ   = 2'd0;
  localparam logic [1:0] K_STORE  = 2'd1;
  localparam logic [1:0] K_IFETCH = 2'd2;

  localparam logic [2:0] FC_BOUND = 3'd1;
  localparam logic [2:0] FC_PAGE  = 3'd2;

  // cycle bits for status[10:3], highest first
  function automatic logic [7:0] cyc_bits(input st_e s);
    case (s)
      S_DPAGE_RD, S_DPAGE_WB: cyc_bits = 8'b1000_0000;
      S_DSEG_RD:              cyc_bits = 8'b0100_0000;
      S_DSEG_PG_RD:           cyc_bits = 8'b0010_0000;
      S_PAGE_RD, S_PAGE_WB:   cyc_bits = 8'b0001_0000;
      S_PAGE_PEEK:            cyc_bits = 8'b0000_1000;
      S_FIN_PG:               cyc_bits = 8'b0000_0100;
      S_FIN_FLAT:             cyc_bits = 8'b0000_0010;
      S_FIN_ABS:              cyc_bits = 8'b0000_0001;
      default:                cyc_bits = 8'b0000_0000;
    endcase
  endfunction

  // next cycle once the segment descriptor is known
  function automatic st_e pick_target(input logic seg_paged, input logic pg_hit,
                                      input logic pg_m, input logic store,
                                      input logic peek);
    if (!seg_paged)          pick_target = S_FIN_FLAT;
    else if (!pg_hit)        pick_target = S_PAGE_RD;
    else if (store && !pg_m) pick_target = S_PAGE_WB;
    else if (peek)           pick_target = S_PAGE_PEEK;
    else                     pick_target = S_FIN_PG;
  endfunction

endpackage

// File: rtl/segx_bounds.sv
module segx_bounds
  import segx_pkg::*;
#(
  parameter int SEG_W = 15,
  parameter int BND_W = 11
) (
  input  st_e              state,
  input  logic [SEG_W-1:0] seg,
  input  logic [SEG_W-1:0] seg_limit,
  input  logic [BND_W-1:0] off_blk,
  input  logic [BND_W-1:0] off_limit,
  output logic             viol
);
  logic seg_chk, off_chk;

  always_comb begin
    seg_chk = (state == S_DSEG_RD) || (state == S_DPAGE_RD) || (state == S_DPAGE_WB);
    off_chk = (state == S_PAGE_RD) || (state == S_PAGE_WB) || (state == S_PAGE_PEEK) ||
              (state == S_FIN_PG)  || (state == S_FIN_FLAT);
    viol = (seg_chk && (seg > seg_limit)) || (off_chk && (off_blk > off_limit));
  end
endmodule

// File: rtl/segx_status.sv
module segx_status #(
  parameter int CB_W = 8,
  parameter int FC_W = 3,
  localparam int ST_W = CB_W + 1 + FC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic            load_ifetch,
  input  logic [CB_W-1:0] load_bits,
  input  logic            fc_en,
  input  logic [FC_W-1:0] fc_val,
  output logic [ST_W-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else begin
      if (load_en) status[ST_W-1:FC_W] <= {load_ifetch, load_bits};
      if (fc_en)   status[FC_W-1:0]    <= fc_val;
    end
  end

  AST_CYC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(status[ST_W-2:FC_W])); // R9

  AST_FCODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fc_en |=> $stable(status[FC_W-1:0])); // R10
endmodule

// File: rtl/segx_top.sv
module segx_top
  import segx_pkg::*;
#(
  parameter int SEG_W     = 15,
  parameter int OFF_W     = 18,
  parameter int ADDR_W    = 24,
  parameter int WORD_W    = 36,
  parameter int PAGE_W    = 10,
  parameter int BND_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_kind,
  input  logic              req_prepage,
  input  logic              req_abs,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [ADDR_W-1:0] dbase_addr,
  input  logic [SEG_W-1:0]  dbase_bound,
  input  logic              dbase_paged,
  input  logic              desc_hit,
  input  logic [WORD_W-1:0] desc_word,
  input  logic              pte_hit,
  input  logic [WORD_W-1:0] pte_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              fault,
  output logic [2:0]        fault_code,
  output logic [11:0]       cyc_status
);
  localparam int FRAME_W = ADDR_W - PAGE_W;
  localparam int BND_W   = OFF_W - BND_SHIFT;
  localparam int SD_BND_LSB = 1;
  localparam int SD_PG_BIT  = 0;
  localparam int PT_F = 0;
  localparam int PT_M = 1;
  localparam int PT_U = 2;

  st_e               state;
  logic              issued;
  logic [SEG_W-1:0]  seg_r, dbb_r;
  logic [OFF_W-1:0]  off_r;
  logic [1:0]        kind_r;
  logic              pre_r;
  logic [ADDR_W-1:0] dba_r;
  logic [WORD_W-1:0] wdata_r, sdw_r, pte_r, pthw_r;
  logic              pth_r;

  logic [ADDR_W-1:0] sd_base, pte_loc, dpte_loc, cur_addr;
  logic [BND_W-1:0]  sd_bnd;
  logic [FRAME_W-1:0] frame;
  logic              is_store, cur_we, viol, fault_set;
  logic [WORD_W-1:0] cur_wdata, src_sdw, hit_pte;
  logic              hit_pg;
  logic [2:0]        fc_nx;
  st_e               tgt;

  assign sd_base   = sdw_r[WORD_W-1 -: ADDR_W];
  assign sd_bnd    = sdw_r[SD_BND_LSB +: BND_W];
  assign frame     = pte_r[WORD_W-1 -: FRAME_W];
  assign pte_loc   = sd_base + ADDR_W'(off_r[OFF_W-1:PAGE_W]);
  assign dpte_loc  = dba_r + ADDR_W'(seg_r[SEG_W-1:PAGE_W]);
  assign is_store  = (kind_r == K_STORE);
  assign req_ready = (state == S_IDLE);

  segx_bounds #(.SEG_W(SEG_W), .BND_W(BND_W)) u_bounds (
    .state    (state),
    .seg      (seg_r),
    .seg_limit(dbb_r),
    .off_blk  (off_r[OFF_W-1 -: BND_W]),
    .off_limit(sd_bnd),
    .viol     (viol)
  );

  // target after the descriptor is known (from lookaside in idle, memory later)
  always_comb begin
    if (state == S_IDLE) begin
      src_sdw = desc_word;
      hit_pg  = pte_hit;
      hit_pte = pte_word;
      tgt = pick_target(desc_word[SD_PG_BIT], pte_hit, pte_word[PT_M],
                        req_kind == K_STORE, req_prepage);
    end else begin
      src_sdw = mem_rdata;
      hit_pg  = pth_r;
      hit_pte = pthw_r;
      tgt = pick_target(mem_rdata[SD_PG_BIT], pth_r, pthw_r[PT_M], is_store, pre_r);
    end
  end

  // address, direction and data of the current cycle
  always_comb begin
    cur_addr  = '0;
    cur_we    = 1'b0;
    cur_wdata = '0;
    case (state)
      S_DSEG_RD:    cur_addr = dba_r + ADDR_W'(seg_r);
      S_DPAGE_RD:   cur_addr = dpte_loc;
      S_DPAGE_WB: begin
        cur_addr  = dpte_loc;
        cur_we    = 1'b1;
        cur_wdata = pte_r | (WORD_W'(1) << PT_U);
      end
      S_DSEG_PG_RD: cur_addr = {frame, seg_r[PAGE_W-1:0]};
      S_PAGE_RD:    cur_addr = pte_loc;
      S_PAGE_WB: begin
        cur_addr  = pte_loc;
        cur_we    = 1'b1;
        cur_wdata = pte_r | (WORD_W'(1) << PT_U) | (WORD_W'(is_store) << PT_M);
      end
      S_PAGE_PEEK:  cur_addr = pte_loc + ADDR_W'(1);
      S_FIN_PG: begin
        cur_addr  = {frame, off_r[PAGE_W-1:0]};
        cur_we    = is_store;
        cur_wdata = wdata_r;
      end
      S_FIN_FLAT: begin
        cur_addr  = sd_base + ADDR_W'(off_r);
        cur_we    = is_store;
        cur_wdata = wdata_r;
      end
      S_FIN_ABS: begin
        cur_addr  = ADDR_W'(off_r);
        cur_we    = is_store;
        cur_wdata = wdata_r;
      end
      default: ;
    endcase
  end

  always_comb begin
    fault_set = 1'b0;
    fc_nx     = FC_BOUND;
    if (state != S_IDLE && !issued && viol) begin
      fault_set = 1'b1;
    end else if (issued && mem_ack && mem_rdata[PT_F] &&
                 (state == S_DPAGE_RD || state == S_PAGE_RD || state == S_PAGE_PEEK)) begin
      fault_set = 1'b1;
      fc_nx     = FC_PAGE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      issued     <= 1'b0;
      seg_r      <= '0;
      dbb_r      <= '0;
      off_r      <= '0;
      kind_r     <= K_READ;
      pre_r      <= 1'b0;
      dba_r      <= '0;
      wdata_r    <= '0;
      sdw_r      <= '0;
      pte_r      <= '0;
      pth_r      <= 1'b0;
      pthw_r     <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      rsp_addr   <= '0;
      rsp_rdata  <= '0;
      fault      <= 1'b0;
      fault_code <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      fault   <= 1'b0;
      if (state == S_IDLE) begin
        if (req_valid) begin
          seg_r   <= req_seg;
          off_r   <= req_off;
          kind_r  <= req_kind;
          pre_r   <= req_prepage;
          wdata_r <= req_wdata;
          dba_r   <= dbase_addr;
          dbb_r   <= dbase_bound;
          pth_r   <= hit_pg;
          pthw_r  <= hit_pte;
          issued  <= 1'b0;
          if (req_abs) begin
            state <= S_FIN_ABS;
          end else if (desc_hit) begin
            sdw_r <= src_sdw;
            pte_r <= hit_pte;
            state <= tgt;
          end else begin
            state <= dbase_paged ? S_DPAGE_RD : S_DSEG_RD;
          end
        end
      end else if (fault_set) begin
        fault      <= 1'b1;
        fault_code <= fc_nx;
        issued     <= 1'b0;
        state      <= S_IDLE;
      end else if (!issued) begin
        mem_req   <= 1'b1;
        mem_we    <= cur_we;
        mem_addr  <= cur_addr;
        mem_wdata <= cur_wdata;
        issued    <= 1'b1;
      end else if (mem_ack) begin
        issued <= 1'b0;
        case (state)
          S_DSEG_RD, S_DSEG_PG_RD: begin
            sdw_r <= src_sdw;
            pte_r <= pthw_r;
            state <= tgt;
          end
          S_DPAGE_RD: begin
            pte_r <= mem_rdata;
            state <= S_DPAGE_WB;
          end
          S_DPAGE_WB:  state <= S_DSEG_PG_RD;
          S_PAGE_RD: begin
            pte_r <= mem_rdata;
            state <= S_PAGE_WB;
          end
          S_PAGE_WB:   state <= pre_r ? S_PAGE_PEEK : S_FIN_PG;
          S_PAGE_PEEK: state <= S_FIN_PG;
          default: begin
            done      <= 1'b1;
            rsp_addr  <= mem_addr;
            rsp_rdata <= mem_we ? '0 : mem_rdata;
            state     <= S_IDLE;
          end
        endcase
      end
    end
  end

  segx_status #(.CB_W(8), .FC_W(3)) u_status (
    .clk        (clk),
    .rst        (rst),
    .load_en    ((state != S_IDLE) && !issued),
    .load_ifetch(kind_r == K_IFETCH),
    .load_bits  (cyc_bits(state)),
    .fc_en      (fault_set),
    .fc_val     (fc_nx),
    .status     (cyc_status)
  );

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R2

  AST_DONE_NOT_FAULT: assert property (@(posedge clk) disable iff (rst)
    done |-> !fault); // R2

  AST_DPAGE_WB_NEXT: assert property (@(posedge clk) disable iff (rst)
    (state == S_DPAGE_RD) |=> (state == S_DPAGE_RD || state == S_DPAGE_WB || state == S_IDLE)); // R3

  AST_WRITE_CYCLES: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (state == S_DPAGE_WB || state == S_PAGE_WB || state == S_FIN_PG ||
                             state == S_FIN_FLAT || state == S_FIN_ABS)); // R4

  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (rst)
    fault |-> (state == S_IDLE && !mem_req)); // R8
endmodule

// File: tb/segx_top_tb.sv
`timescale 1ns/1ps
module segx_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_prepage = 0, req_abs = 0;
  logic [14:0] req_seg = 0;
  logic [17:0] req_off = 0;
  logic [1:0]  req_kind = 0;
  logic [35:0] req_wdata = 0;
  logic [23:0] dbase_addr = 0;
  logic [14:0] dbase_bound = 0;
  logic        dbase_paged = 0;
  logic        desc_hit = 0, pte_hit = 0;
  logic [35:0] desc_word = 0, pte_word = 0;
  logic        req_ready, mem_req, mem_we, done, fault;
  logic [23:0] mem_addr, rsp_addr;
  logic [35:0] mem_wdata, rsp_rdata;
  logic        mem_ack;
  logic [35:0] mem_rdata;
  logic [2:0]  fault_code;
  logic [11:0] cyc_status;

  segx_top u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_kind(req_kind),
    .req_prepage(req_prepage), .req_abs(req_abs), .req_wdata(req_wdata),
    .dbase_addr(dbase_addr), .dbase_bound(dbase_bound), .dbase_paged(dbase_paged),
    .desc_hit(desc_hit), .desc_word(desc_word), .pte_hit(pte_hit), .pte_word(pte_word),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .rsp_addr(rsp_addr),
    .rsp_rdata(rsp_rdata), .fault(fault), .fault_code(fault_code), .cyc_status(cyc_status)
  );

  // memory model, one-cycle latency, with access log
  logic [35:0] mem [4096];
  logic [23:0] log_addr [256];
  logic        log_we [256];
  int          log_n = 0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req;
      if (mem_req) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[11:0]];
        log_addr[log_n[7:0]] <= mem_addr;
        log_we[log_n[7:0]]   <= mem_we;
        log_n <= log_n + 1;
      end
    end
  end

  int checks = 0, fails = 0;
  logic        r_done, r_fault;
  logic [2:0]  r_code;
  logic [23:0] r_addr;
  logic [35:0] r_data;
  int          base;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] mk_sd(input logic [23:0] a, input logic [10:0] b, input logic pg);
    return {a, b, pg};
  endfunction

  function automatic logic [35:0] mk_pt(input logic [13:0] fr, input logic u, input logic m, input logic f);
    return {fr, 19'd0, u, m, f};
  endfunction

  task automatic issue(input logic [14:0] seg, input logic [17:0] off, input logic [1:0] kind,
                       input logic pre, input logic ab, input logic [35:0] wd);
    @(negedge clk);
    base = log_n;
    req_seg = seg; req_off = off; req_kind = kind; req_prepage = pre;
    req_abs = ab; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_done = 0; r_fault = 0; r_code = 0; r_addr = 0; r_data = 0;
    for (int i = 0; i < 200; i++) begin
      if (done || fault) begin
        r_done = done; r_fault = fault; r_code = fault_code;
        r_addr = rsp_addr; r_data = rsp_rdata;
        break;
      end
      @(negedge clk);
    end
    chk("completion seen", 64'(r_done | r_fault), 64'd1);
  endtask

  task automatic chk_acc(input string tag, input int idx, input logic [23:0] a, input logic we);
    chk(tag, {39'd0, log_we[(base + idx) % 256], log_addr[(base + idx) % 256]}, {39'd0, we, a});
  endtask

  task automatic t_reset;
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 mem_req", 64'(mem_req), 64'd0);
    chk("R1 done/fault", 64'({done, fault}), 64'd0);
    chk("R1 cyc_status", 64'(cyc_status), 64'd0);
  endtask

  task automatic t_flat_read;
    dbase_addr = 24'h100; dbase_bound = 15'h7FFF; dbase_paged = 0;
    desc_hit = 0; pte_hit = 0;
    mem[12'h105] = mk_sd(24'h400, 11'h7FF, 1'b0);
    mem[12'h412] = 36'h0_ABCD_1234;
    issue(15'd5, 18'h12, 2'd0, 0, 0, 0);
    chk("R2 done", 64'(r_done), 64'd1);
    chk("R2 access count", 64'(log_n - base), 64'd2);
    chk_acc("R2 descriptor read", 0, 24'h105, 0);
    chk_acc("R2 final read", 1, 24'h412, 0);
    chk("R2 rsp_addr", 64'(r_addr), 64'h412);
    chk("R12 read data", 64'(r_data), 64'h0_ABCD_1234);
    chk("R9 flat final status", 64'(cyc_status), 64'h010);
    @(negedge clk);
    chk("R2 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_paged_store;
    dbase_addr = 24'h140; dbase_paged = 1;
    mem[12'h141] = mk_pt(14'd1, 0, 0, 0);
    mem[12'h405] = mk_sd(24'h600, 11'h7FF, 1'b1);
    mem[12'h603] = mk_pt(14'd2, 0, 0, 0);
    issue(15'h405, 18'h0C23, 2'd1, 0, 0, 36'h5_5555_AAAA);
    chk("R3 access count", 64'(log_n - base), 64'd6);
    chk_acc("R3 table entry read", 0, 24'h141, 0);
    chk_acc("R3 write-back follows", 1, 24'h141, 1);
    chk_acc("R3 paged descriptor read", 2, 24'h405, 0);
    chk_acc("R4 page entry read", 3, 24'h603, 0);
    chk_acc("R4 page entry write-back", 4, 24'h603, 1);
    chk_acc("R4 paged final write", 5, 24'h823, 1);
    chk("R3 U set in table entry", 64'(mem[12'h141]), 64'(mk_pt(14'd1, 1, 0, 0)));
    chk("R4 U and M set on store", 64'(mem[12'h603]), 64'(mk_pt(14'd2, 1, 1, 0)));
    chk("R12 store data", 64'(mem[12'h823]), 64'h5_5555_AAAA);
    chk("R4 rsp_addr", 64'(r_addr), 64'h823);
    chk("R9 paged final status", 64'(cyc_status), 64'h020);
  endtask

  task automatic t_ifetch;
    dbase_addr = 24'h100; dbase_paged = 0;
    issue(15'd5, 18'h12, 2'd2, 0, 0, 0);
    chk("R9 ifetch status", 64'(cyc_status), 64'h810);
    chk("R12 ifetch data", 64'(r_data), 64'h0_ABCD_1234);
  endtask

  task automatic t_desc_hit;
    desc_hit = 1; desc_word = mk_sd(24'h600, 11'h7FF, 1'b1); pte_hit = 0;
    mem[12'h605] = mk_pt(14'd3, 0, 0, 0);
    mem[12'hC05] = 36'h1_2345_6789;
    issue(15'd9, 18'h1405, 2'd0, 0, 0, 0);
    chk("R5 descriptor hit count", 64'(log_n - base), 64'd3);
    chk_acc("R5 page read first", 0, 24'h605, 0);
    chk_acc("R4 write-back", 1, 24'h605, 1);
    chk_acc("R4 final", 2, 24'hC05, 0);
    chk("R4 U only on read", 64'(mem[12'h605]), 64'(mk_pt(14'd3, 1, 0, 0)));
    chk("R12 paged read data", 64'(r_data), 64'h1_2345_6789);
  endtask

  task automatic t_both_hit;
    desc_hit = 1; pte_hit = 1; pte_word = mk_pt(14'd3, 1, 0, 0);
    issue(15'd9, 18'h1405, 2'd0, 0, 0, 0);
    chk("R5 both hit read count", 64'(log_n - base), 64'd1);
    chk_acc("R5 only final", 0, 24'hC05, 0);
    issue(15'd9, 18'h1405, 2'd1, 0, 0, 36'h7_0000_0007);
    chk("R5 hit store clean count", 64'(log_n - base), 64'd2);
    chk_acc("R5 write-back kept", 0, 24'h605, 1);
    chk_acc("R5 final store", 1, 24'hC05, 1);
    chk("R5 M set", 64'(mem[12'h605]), 64'(mk_pt(14'd3, 1, 1, 0)));
    chk("R9 write-back shares page bit", 64'(cyc_status), 64'h020);
    pte_hit = 0;
  endtask

  task automatic t_prepage;
    desc_hit = 1; pte_hit = 0;
    mem[12'h606] = mk_pt(14'd1, 0, 0, 0);
    mem[12'h607] = mk_pt(14'd0, 0, 0, 1);
    issue(15'd9, 18'h1405, 2'd0, 1, 0, 0);
    chk("R6 prepage count", 64'(log_n - base), 64'd4);
    chk_acc("R6 peek after write-back", 2, 24'h606, 0);
    chk_acc("R6 final uses own frame", 3, 24'hC05, 0);
    issue(15'd9, 18'h1805, 2'd0, 1, 0, 0);
    chk("R6 peek fault", 64'({r_fault, r_code}), 64'({1'b1, 3'd2}));
    chk("R8 stop after peek", 64'(log_n - base), 64'd3);
    chk("R9 peek status", 64'(cyc_status), 64'h042);
    chk("R6 peeked entry untouched", 64'(mem[12'h607]), 64'(mk_pt(14'd0, 0, 0, 1)));
  endtask

  task automatic t_page_faults;
    desc_hit = 1;
    issue(15'd9, 18'h1C00, 2'd0, 0, 0, 0);
    chk("R8 page entry fault", 64'({r_fault, r_code}), 64'({1'b1, 3'd2}));
    chk("R8 one access", 64'(log_n - base), 64'd1);
    chk("R9 page status", 64'(cyc_status), 64'h082);
    desc_hit = 0; dbase_addr = 24'h140; dbase_paged = 1;
    mem[12'h142] = mk_pt(14'd1, 0, 0, 1);
    issue(15'h805, 18'h0, 2'd0, 0, 0, 0);
    chk("R8 table entry fault", 64'({r_fault, r_code}), 64'({1'b1, 3'd2}));
    chk("R8 no write-back", 64'(log_n - base), 64'd1);
    chk("R9 table entry status", 64'(cyc_status), 64'h402);
  endtask

  task automatic t_bounds;
    desc_hit = 0; dbase_addr = 24'h100; dbase_paged = 0; dbase_bound = 15'd4;
    issue(15'd5, 18'h12, 2'd0, 0, 0, 0);
    chk("R7 segment bound fault", 64'({r_fault, r_code}), 64'({1'b1, 3'd1}));
    chk("R7 no access", 64'(log_n - base), 64'd0);
    chk("R9 flat descriptor status", 64'(cyc_status), 64'h201);
    dbase_bound = 15'h7FFF;
    mem[12'h106] = mk_sd(24'h400, 11'd1, 1'b0);
    issue(15'd6, 18'h200, 2'd0, 0, 0, 0);
    chk("R7 offset bound fault", 64'({r_fault, r_code}), 64'({1'b1, 3'd1}));
    chk("R7 stop before final", 64'(log_n - base), 64'd1);
    chk("R7 status", 64'(cyc_status), 64'h011);
  endtask

  task automatic t_code_kept;
    issue(15'd5, 18'h12, 2'd0, 0, 0, 0);
    chk("R10 done", 64'(r_done), 64'd1);
    chk("R10 fault code kept", 64'(cyc_status), 64'h011);
  endtask

  task automatic t_abs;
    issue(15'd0, 18'h777, 2'd1, 0, 1, 36'h3_CAFE_0001);
    chk("R11 one access", 64'(log_n - base), 64'd1);
    chk_acc("R11 raw address", 0, 24'h777, 1);
    chk("R11 status", 64'(cyc_status), 64'h009);
    chk("R12 absolute store", 64'(mem[12'h777]), 64'h3_CAFE_0001);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_flat_read();
    t_paged_store();
    t_ifetch();
    t_desc_hit();
    t_both_hit();
    t_prepage();
    t_page_faults();
    t_bounds();
    t_code_kept();
    t_abs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule